// File: doc/BRIEF.md
# Dual-Bank Host Interface Buffer

This block places two equal banks of word RAM between an external host bus and an on-chip CPU bus. At any moment the host side owns one bank and the CPU owns the other. A swap command from the CPU exchanges the two, so one side can fill a bank while the other drains the previous one. Data never has to be copied between the sides.

The host reaches the buffer through four registers: a word address, a streaming mode, a data port and a status word. The host loads the address and then picks a streaming direction. After that, each access to the data port moves one word at the current address and advances the address. Any other register access leaves streaming mode, so the host must repeat the setup. The CPU paces an external DMA engine by raising a request line. When the host side moves the last word of its bank, the block drops that request and raises a pending bank interrupt to the CPU. The CPU then swaps the banks and triggers the DMA again.

Top module: `hif_dual_bank_buf`

## Requirements
- R1: After reset the host owns bank 0 and the CPU owns bank 1. The address and mode are 0, `dma_req` and `bank_irq` are low, and both read-data outputs are 0.
- R2: Host register selection applies when `host_rs` is high: `host_sel` 0 is the address register (a 5-bit word index, readable), 1 is the mode register (bits [1:0], readable), 2 is the data port and 3 is the status word. A host write made with `host_rs` low has no effect. Host read data appears on `host_rdata` one cycle after the read and then holds.
- R3: With mode 2'b10, each data-port write stores the word at the current index of the host bank, and the index then increments.
- R4: With mode 2'b01, each data-port read returns the word at the current index of the host bank on the next cycle, and the index then increments.
- R5: A data-port access that does not match the mode (a write outside 2'b10, or a read outside 2'b01) leaves the RAM and the address unchanged. Such a read returns 0.
- R6: A host access with `host_rs` high to the address register, to the status word, or a read of the mode register, clears the mode to 2'b00.
- R7: A host read with `host_rs` low returns the status word and leaves the mode and address unchanged. The status word holds bit 4 = bank owned by the host, bit 3 = `bank_irq`, bit 2 = `dma_req`, bits [1:0] = mode.
- R8: A CPU write to the control register (`cpu_reg` high) with bit 0 set raises `dma_req` on the next cycle. If this happens in the same cycle as an end-of-bank access, the trigger wins.
- R9: A streaming data access at index 31 sets `bank_irq` and clears `dma_req`. The index wraps to 0 and the mode stays set.
- R10: `bank_irq` stays high until the CPU writes a 1 to control bit 1. If a clear and an end-of-bank access fall in the same cycle, the interrupt stays set.
- R11: A CPU control write with bit 2 set swaps bank ownership from the next cycle. Words written by one side become visible to the other side after a swap.
- R12: CPU accesses with `cpu_reg` low reach the bank the CPU owns, at `cpu_addr`. A CPU control read returns bit 0 = `dma_req`, bit 1 = `bank_irq`, bit 2 = bank owned by the host. CPU read data appears one cycle after the read and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_rs | input | 1 | Register-select qualifier; low forces a status read |
| host_sel | input | 2 | Host register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| cpu_en | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_reg | input | 1 | CPU targets the control register (1) or its RAM bank (0) |
| cpu_addr | input | 5 | CPU word index in its bank |
| cpu_wdata | input | 32 | CPU write data or control command |
| cpu_rdata | output | 32 | CPU read data, registered |
| dma_req | output | 1 | Request toward the external DMA engine |
| bank_irq | output | 1 | Pending end-of-bank interrupt to the CPU |

## Verification
The assertions assume that every strobe and select input carries a defined 0 or 1 on each rising edge. They also assume that reset is held for at least one edge before any access. No ordering of host and CPU commands is assumed: swaps, triggers and clears may collide with end-of-bank accesses in any cycle, and the properties are written to state the resulting priority. The bench drives every input to a known value at the falling edge, including during reset. It keeps the directed phases in step with the model, and its random phase mixes swaps, triggers and streaming accesses freely.

// File: rtl/hif_buf_pkg.sv
`timescale 1ns/1ps
package hif_buf_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_MODE = 2'd1,
      SEL_DATA = 2'd2,
      SEL_STAT = 2'd3
   } host_sel_e;

   localparam logic [1:0] MODE_RD = 2'b01;
   localparam logic [1:0] MODE_WR = 2'b10;

   // CPU control command bit positions
   localparam int CTL_TRIG  = 0;
   localparam int CTL_CLEAR = 1;
   localparam int CTL_SWAP  = 2;
   localparam int CTL_W     = 3;

   localparam int STAT_W = 5;
endpackage

// File: rtl/hif_host_port.sv
`timescale 1ns/1ps
module hif_host_port
   import hif_buf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              we,
   input  logic              rs,
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              hbank,
   input  logic              irq,
   input  logic              dreq,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              rd_en,
   output logic [DATA_W-1:0] rd_val,
   output logic              end_hit
);
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        mode_q;
   logic              reg_acc, data_acc, wr_ok, rd_ok, step, cancel;
   logic [DATA_W-1:0] stat_word;

   assign reg_acc  = cs & rs;
   assign data_acc = reg_acc && (sel == SEL_DATA);
   assign wr_ok    = data_acc & we & (mode_q == MODE_WR);
   assign rd_ok    = data_acc & ~we & (mode_q == MODE_RD);
   assign step     = wr_ok | rd_ok;
   assign end_hit  = step & (addr_q == {ADDR_W{1'b1}});
   assign cancel   = reg_acc & ((sel == SEL_ADDR) | (sel == SEL_STAT) |
                                ((sel == SEL_MODE) & ~we));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mode_q <= '0;
      end else begin
         if (reg_acc && we && sel == SEL_ADDR) addr_q <= wdata[ADDR_W-1:0];
         else if (step)                        addr_q <= addr_q + 1'b1;
         if (reg_acc && we && sel == SEL_MODE) mode_q <= wdata[1:0];
         else if (cancel)                      mode_q <= '0;
      end
   end

   always_comb begin
      stat_word = '0;
      stat_word[STAT_W-1:0] = {hbank, irq, dreq, mode_q};
   end

   assign rd_en    = cs & ~we;
   assign ram_we   = wr_ok;
   assign ram_addr = addr_q;

   always_comb begin
      rd_val = '0;
      if (!rs) rd_val = stat_word;
      else begin
         unique case (sel)
            SEL_ADDR: rd_val[ADDR_W-1:0] = addr_q;
            SEL_MODE: rd_val[1:0]        = mode_q;
            SEL_DATA: rd_val             = rd_ok ? ram_rdata : '0;
            default:  rd_val             = stat_word;
         endcase
      end
   end

   AST_MODE_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      cs && rs && (sel == SEL_ADDR || sel == SEL_STAT || (sel == SEL_MODE && !we))
      |=> mode_q == 2'b00); // R6

   AST_STATUS_NO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      cs && !rs |=> $stable(mode_q) && $stable(addr_q)); // R7

   AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      cs && rs && sel == SEL_DATA &&
      ((we && mode_q == MODE_WR) || (!we && mode_q == MODE_RD))
      |=> addr_q == ADDR_W'($past(addr_q) + 1'b1)); // R3

   AST_MISMATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cs && rs && sel == SEL_DATA &&
      !((we && mode_q == MODE_WR) || (!we && mode_q == MODE_RD))
      |=> $stable(addr_q) && $stable(mode_q)); // R5
endmodule

// File: rtl/hif_bank_ram.sv
`timescale 1ns/1ps
module hif_bank_ram #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 32,
   parameter int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              hbank,
   input  logic              h_we,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   input  logic              c_we,
   input  logic [ADDR_W-1:0] c_addr,
   input  logic [DATA_W-1:0] c_wdata,
   output logic [DATA_W-1:0] c_rdata
);
   localparam int NBANK = 2;

   logic [DATA_W-1:0] rd_h [NBANK];
   logic [DATA_W-1:0] rd_c [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [DATA_W-1:0] mem [WORDS];
      logic              host_owns;
      assign host_owns = (hbank == 1'(b));
      always_ff @(posedge clk) begin
         if (host_owns && h_we)       mem[h_addr] <= h_wdata;
         else if (!host_owns && c_we) mem[c_addr] <= c_wdata;
      end
      assign rd_h[b] = mem[h_addr];
      assign rd_c[b] = mem[c_addr];
   end

   assign h_rdata = rd_h[hbank];
   assign c_rdata = rd_c[~hbank];
endmodule

// File: rtl/hif_cpu_ctrl.sv
`timescale 1ns/1ps
module hif_cpu_ctrl
   import hif_buf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             c_en,
   input  logic             c_we,
   input  logic             c_reg,
   input  logic [CTL_W-1:0] c_cmd,
   input  logic             end_hit,
   output logic             hbank,
   output logic             irq,
   output logic             dreq
);
   logic ctl_wr, trig, clr, swap;

   assign ctl_wr = c_en & c_we & c_reg;
   assign trig   = ctl_wr & c_cmd[CTL_TRIG];
   assign clr    = ctl_wr & c_cmd[CTL_CLEAR];
   assign swap   = ctl_wr & c_cmd[CTL_SWAP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hbank <= 1'b0;
         irq   <= 1'b0;
         dreq  <= 1'b0;
      end else begin
         if (swap) hbank <= ~hbank;
         if (end_hit)  irq <= 1'b1;
         else if (clr) irq <= 1'b0;
         if (trig)         dreq <= 1'b1;
         else if (end_hit) dreq <= 1'b0;
      end
   end

   AST_TRIG_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> dreq); // R8

   AST_END_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      end_hit |=> irq); // R9

   AST_END_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      end_hit && !trig |=> !dreq); // R9

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !clr |=> irq); // R10

   AST_SWAP_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> hbank != $past(hbank)); // R11
endmodule

// File: rtl/hif_dual_bank_buf.sv
`timescale 1ns/1ps
module hif_dual_bank_buf
   import hif_buf_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int WORDS       = 32,
   parameter bit HOST_RD_REG = 1'b1,
   localparam int ADDR_W     = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs,
   input  logic              host_we,
   input  logic              host_rs,
   input  logic [1:0]        host_sel,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              cpu_en,
   input  logic              cpu_we,
   input  logic              cpu_reg,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              dma_req,
   output logic              bank_irq
);
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0)
      $error("WORDS must be a power of two of at least 2");
   if (DATA_W < STAT_W || DATA_W <= ADDR_W)
      $error("DATA_W too narrow for status and address fields");

   logic              hbank, ram_hwe, rd_en, end_hit;
   logic [ADDR_W-1:0] ram_haddr;
   logic [DATA_W-1:0] ram_hrd, ram_crd, rd_val, ctl_word;

   hif_host_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_host (
      .clk(clk), .rst_n(rst_n), .cs(host_cs), .we(host_we), .rs(host_rs),
      .sel(host_sel), .wdata(host_wdata), .hbank(hbank), .irq(bank_irq),
      .dreq(dma_req), .ram_rdata(ram_hrd), .ram_we(ram_hwe),
      .ram_addr(ram_haddr), .rd_en(rd_en), .rd_val(rd_val), .end_hit(end_hit)
   );

   hif_bank_ram #(.DATA_W(DATA_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .hbank(hbank), .h_we(ram_hwe), .h_addr(ram_haddr),
      .h_wdata(host_wdata), .h_rdata(ram_hrd),
      .c_we(cpu_en & cpu_we & ~cpu_reg), .c_addr(cpu_addr),
      .c_wdata(cpu_wdata), .c_rdata(ram_crd)
   );

   hif_cpu_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .c_en(cpu_en), .c_we(cpu_we), .c_reg(cpu_reg),
      .c_cmd(cpu_wdata[CTL_W-1:0]), .end_hit(end_hit),
      .hbank(hbank), .irq(bank_irq), .dreq(dma_req)
   );

   always_comb begin
      ctl_word = '0;
      ctl_word[CTL_W-1:0] = {hbank, bank_irq, dma_req};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cpu_rdata <= '0;
      else if (cpu_en && !cpu_we) cpu_rdata <= cpu_reg ? ctl_word : ram_crd;
   end

   if (HOST_RD_REG) begin : g_host_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     host_rdata <= '0;
         else if (rd_en) host_rdata <= rd_val;
      end
   end else begin : g_host_rd_comb
      assign host_rdata = rd_en ? rd_val : '0;
   end

   AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_irq) |-> $past(host_cs) && $past(host_rs)); // R9

   AST_SWAP_ONLY_BY_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_en && cpu_we && cpu_reg) |=> $stable(hbank)); // R11
endmodule

// File: tb/hif_dual_bank_buf_tb.sv
`timescale 1ns/1ps
module hif_dual_bank_buf_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_cs = 0, h_we = 0, h_rs = 0;
   logic [1:0]  h_sel = 0;
   logic [31:0] h_wd = 0;
   logic        c_en = 0, c_we = 0, c_reg = 0;
   logic [4:0]  c_addr = 0;
   logic [31:0] c_wd = 0;
   logic [31:0] host_rdata, cpu_rdata;
   logic        dma_req, bank_irq;

   int checks = 0, errors = 0;
   bit finished = 0;
   string tag = "R1";

   // reference state
   logic [31:0] m_mem [64];
   bit          m_hb, m_irq, m_dreq;
   bit [1:0]    m_mode;
   bit [4:0]    m_addr;
   logic [31:0] e_hrd = 0, e_crd = 0;

   always #4 clk = ~clk;

   hif_dual_bank_buf u_dut (
      .clk(clk), .rst_n(rst_n), .host_cs(h_cs), .host_we(h_we), .host_rs(h_rs),
      .host_sel(h_sel), .host_wdata(h_wd), .host_rdata(host_rdata),
      .cpu_en(c_en), .cpu_we(c_we), .cpu_reg(c_reg), .cpu_addr(c_addr),
      .cpu_wdata(c_wd), .cpu_rdata(cpu_rdata), .dma_req(dma_req), .bank_irq(bank_irq)
   );

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_apply();
      logic [31:0] st;
      bit end_h, trig, clr, sw, adv;
      bit [1:0] mo;
      bit [4:0] a;
      int idx;
      end_h = 0; trig = 0; clr = 0; sw = 0; adv = 0;
      mo = m_mode; a = m_addr;
      st = {27'd0, m_hb, m_irq, m_dreq, m_mode};
      if (h_cs) begin
         if (!h_rs) begin
            if (!h_we) e_hrd = st;
         end else begin
            case (h_sel)
               2'd0: begin
                  if (h_we) m_addr = h_wd[4:0]; else e_hrd = {27'd0, m_addr};
                  m_mode = 0;
               end
               2'd1: begin
                  if (h_we) m_mode = h_wd[1:0];
                  else begin e_hrd = {30'd0, m_mode}; m_mode = 0; end
               end
               2'd2: begin
                  idx = m_hb * 32 + a;
                  if (h_we) begin
                     if (mo == 2'b10) begin m_mem[idx] = h_wd; adv = 1; end
                  end else if (mo == 2'b01) begin
                     e_hrd = m_mem[idx]; adv = 1;
                  end else e_hrd = 0;
                  if (adv) begin end_h = (a == 5'd31); m_addr = a + 5'd1; end
               end
               default: begin
                  if (!h_we) e_hrd = st;
                  m_mode = 0;
               end
            endcase
         end
      end
      if (c_en) begin
         if (c_reg) begin
            if (c_we) begin trig = c_wd[0]; clr = c_wd[1]; sw = c_wd[2]; end
            else e_crd = {29'd0, m_hb, m_irq, m_dreq};
         end else begin
            idx = (m_hb ? 0 : 32) + c_addr;
            if (c_we) m_mem[idx] = c_wd; else e_crd = m_mem[idx];
         end
      end
      m_irq  = end_h | (m_irq & !clr);
      m_dreq = trig | (m_dreq & !end_h);
      m_hb   = m_hb ^ sw;
   endtask

   task automatic compare();
      check("host_rdata", host_rdata, e_hrd);
      check("cpu_rdata", cpu_rdata, e_crd);
      check("dma_req", {31'd0, dma_req}, {31'd0, m_dreq});
      check("bank_irq", {31'd0, bank_irq}, {31'd0, m_irq});
   endtask

   // called at a falling edge with inputs already set
   task automatic tick();
      model_apply();
      @(negedge clk);
      compare();
      h_cs = 0; h_we = 0; h_rs = 0; h_sel = 0; h_wd = 0;
      c_en = 0; c_we = 0; c_reg = 0; c_addr = 0; c_wd = 0;
   endtask

   task automatic set_host(bit we, bit rs, bit [1:0] sel, logic [31:0] wd);
      h_cs = 1; h_we = we; h_rs = rs; h_sel = sel; h_wd = wd;
   endtask

   task automatic set_cpu(bit we, bit rg, bit [4:0] a, logic [31:0] wd);
      c_en = 1; c_we = we; c_reg = rg; c_addr = a; c_wd = wd;
   endtask

   task automatic host(bit we, bit rs, bit [1:0] sel, logic [31:0] wd);
      set_host(we, rs, sel, wd); tick();
   endtask

   task automatic cpu(bit we, bit rg, bit [4:0] a, logic [31:0] wd);
      set_cpu(we, rg, a, wd); tick();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < 64; i++) m_mem[i] = 0;
      m_hb = 0; m_irq = 0; m_dreq = 0; m_mode = 0; m_addr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      tag = "R1"; compare();
      tick();
      tag = "R1_addr"; host(0, 1, 2'd0, 0);

      // R12: CPU fills its bank (bank 1), reads back, control read
      tag = "R12";
      for (int i = 0; i < 32; i++) cpu(1, 0, 5'(i), 32'hB100_0000 + i);
      cpu(0, 0, 5'd3, 0);
      cpu(0, 0, 5'd31, 0);
      cpu(0, 1, 5'd0, 0);
      // R11: swap, CPU now owns bank 0
      tag = "R11";
      cpu(1, 1, 5'd0, 32'h4);
      cpu(0, 1, 5'd0, 0);
      for (int i = 0; i < 32; i++) cpu(1, 0, 5'(i), 32'hA000_0000 + i);
      cpu(1, 1, 5'd0, 32'h4);
      cpu(0, 1, 5'd0, 0);

      // R2: register map and rs-low write
      tag = "R2";
      host(1, 1, 2'd0, 32'd5);
      host(0, 1, 2'd0, 0);
      host(1, 1, 2'd1, 32'd1);
      host(0, 1, 2'd1, 0);
      host(1, 0, 2'd0, 32'd9);
      host(0, 1, 2'd0, 0);

      // R4: consecutive read of CPU-written bank 0
      tag = "R4";
      host(1, 1, 2'd0, 32'd0);
      host(1, 1, 2'd1, 32'd1);
      for (int i = 0; i < 4; i++) host(0, 1, 2'd2, 0);
      // R7: status read with rs low keeps streaming
      tag = "R7";
      host(0, 0, 2'd3, 0);
      host(0, 0, 2'd2, 0);
      host(0, 1, 2'd2, 0);
      // R5: write during read mode ignored
      tag = "R5";
      host(1, 1, 2'd2, 32'hDEAD_BEEF);
      host(0, 1, 2'd2, 0);
      host(0, 0, 2'd0, 0);
      // R6: status read with rs high cancels
      tag = "R6";
      host(0, 1, 2'd3, 0);
      host(0, 1, 2'd2, 0);
      host(0, 0, 2'd0, 0);
      host(1, 1, 2'd1, 32'd2);
      host(1, 1, 2'd0, 32'd4);
      host(0, 0, 2'd0, 0);

      // R3: consecutive write, then read back
      tag = "R3";
      host(1, 1, 2'd0, 32'd10);
      host(1, 1, 2'd1, 32'd2);
      for (int i = 0; i < 3; i++) host(1, 1, 2'd2, 32'hC0DE_0000 + i);
      host(1, 1, 2'd0, 32'd10);
      host(1, 1, 2'd1, 32'd1);
      for (int i = 0; i < 4; i++) host(0, 1, 2'd2, 0);

      // R8: trigger raises request
      tag = "R8";
      cpu(1, 1, 5'd0, 32'h1);
      cpu(0, 1, 5'd0, 0);
      // R9: end of bank
      tag = "R9";
      host(1, 1, 2'd0, 32'd30);
      host(1, 1, 2'd1, 32'd2);
      host(1, 1, 2'd2, 32'h1111_0030);
      host(1, 1, 2'd2, 32'h1111_0031);
      host(0, 0, 2'd0, 0);
      host(1, 1, 2'd2, 32'h1111_0000);
      host(0, 0, 2'd0, 0);
      host(1, 1, 2'd0, 32'd0);
      host(1, 1, 2'd1, 32'd1);
      host(0, 1, 2'd2, 0);
      // R10: interrupt held, cleared, and set wins over clear
      tag = "R10";
      cpu(1, 1, 5'd0, 32'h0);
      tick();
      cpu(1, 1, 5'd0, 32'h2);
      host(1, 1, 2'd0, 32'd31);
      host(1, 1, 2'd1, 32'd2);
      set_host(1, 1, 2'd2, 32'h2222_0031); set_cpu(1, 1, 5'd0, 32'h2); tick();
      cpu(0, 1, 5'd0, 0);
      cpu(1, 1, 5'd0, 32'h2);
      // R8: trigger wins over end of bank
      tag = "R8";
      host(1, 1, 2'd0, 32'd31);
      host(1, 1, 2'd1, 32'd2);
      set_host(1, 1, 2'd2, 32'h3333_0031); set_cpu(1, 1, 5'd0, 32'h3); tick();
      cpu(0, 1, 5'd0, 0);
      // R11: host-written words visible to CPU after swap
      tag = "R11";
      cpu(1, 1, 5'd0, 32'h4);
      cpu(0, 0, 5'd10, 0);
      cpu(0, 0, 5'd31, 0);
      host(1, 1, 2'd0, 32'd3);
      host(1, 1, 2'd1, 32'd1);
      host(0, 1, 2'd2, 0);
      cpu(1, 1, 5'd0, 32'h4);

      // random mix
      tag = "RND";
      for (int n = 0; n < 4000; n++) begin
         int r = $urandom % 16;
         if (r == 2)      set_host(1, 1, 2'd0, $urandom);
         else if (r == 3) set_host(1, 1, 2'd1, ($urandom % 2) ? 32'd1 : 32'd2);
         else if (r == 4) set_host(0, 0, 2'($urandom), 0);
         else if (r == 5) set_host(1, 0, 2'($urandom), $urandom);
         else if (r == 6) set_host(0, 1, 2'($urandom), 0);
         else if (r >= 7) set_host(1'($urandom), 1, 2'd2, $urandom);
         r = $urandom % 8;
         if (r == 4)      set_cpu(1, 0, 5'($urandom), $urandom);
         else if (r == 5) set_cpu(0, 0, 5'($urandom), 0);
         else if (r == 6) set_cpu(0, 1, 5'd0, 0);
         else if (r == 7) set_cpu(1, 1, 5'd0,
                                  {29'd0, ($urandom % 4 == 0), 2'($urandom)});
         tick();
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule